// File: doc/BRIEF.md
# Layer-1 Power-Down and Wake Controller

This block sits in the layer-1 section of a basic-rate S-interface terminal transceiver. It decides when the transceiver's internal clock enables may run. It exchanges 4-bit command and indication codes with a host, and it turns the special test commands into control levels and strobes for the transmitter.

After a hardware reset the block parks in a power-down state. In that state every clock enable is low, but a line-activity input is still watched. A non-idle line, or any command written by the host, marks the block as woken. The clock enables are released only when the block has been woken and the host has also read the deactivated indication at least once. The indication register reports a deactivated, activation-requested or test-mode code. An interrupt flags every change of that code until the host reads it.

Top module: `l1_pwr_ctrl`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it rises, `clk_en_o` is all zeros, `ind_data_o` is 4'b1111, and `irq_o`, `loop_o`, `zeros_o`, `single_zero_o` and `l1_rst_o` are 0.
- R2: `line_active_i` held high wakes the block. Once the indication has also been read, all `clk_en_o` bits are 1 no later than SYNC_STAGES+1 cycles after the line input rose.
- R3: A write on `cmd_we_i` wakes the block whatever the code. If the indication has already been read, `clk_en_o` is all ones in the cycle after the write.
- R4: `clk_en_o` stays all zeros until the host has strobed `ind_re_i` at least once after reset, even when the block has been woken. A read without any wake also leaves it at zero.
- R5: All bits of `clk_en_o` are always equal. Once set, they stay set until the next hardware reset.
- R6: Code 4'b1001 sets `loop_o` and code 4'b0010 sets `zeros_o` in the cycle after the write. Each stays set across other commands until a layer-1 reset command or a hardware reset.
- R7: Code 4'b0001 clears `loop_o`, `zeros_o` and the activation request in the cycle after the write. It also drives `l1_rst_o` high for exactly that one cycle.
- R8: Code 4'b0011 drives `single_zero_o` high for exactly the one cycle after the write and changes no held mode.
- R9: Code 4'b1000 records an activation request. With no test mode held, `ind_data_o` becomes 4'b0100.
- R10: `ind_data_o` is 4'b1010 while loopback or continuous zeros is held (this code overrides 4'b0100), 4'b0100 while only an activation request is held, and 4'b1111 otherwise. It follows a mode change one cycle after the mode outputs.
- R11: `irq_o` rises in the same cycle that `ind_data_o` changes and is cleared by an `ind_re_i` strobe. If a change and a read fall in the same cycle, `irq_o` stays set.
- R12: A command code not listed in R6 to R9 or in R7 changes no mode output and no indication.
- R13: Line activity present only while `rst_ni` is low does not wake the block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| line_active_i | input | 1 | High when the line carries a non-idle signal (asynchronous) |
| cmd_we_i | input | 1 | Command register write strobe |
| cmd_data_i | input | 4 | Command code |
| ind_re_i | input | 1 | Indication register read strobe |
| ind_data_o | output | 4 | Indication code |
| irq_o | output | 1 | Indication-changed interrupt |
| clk_en_o | output | NUM_EN | Internal clock enables |
| loop_o | output | 1 | Analog loopback held |
| zeros_o | output | 1 | Continuous zeros transmission held |
| single_zero_o | output | 1 | One-cycle single-zero send strobe |
| l1_rst_o | output | 1 | One-cycle layer-1 reset strobe |

## Verification
An indication change caused by a mode command can land in the same cycle as a host read strobe on the indication register. The interrupt must then survive, because the new code has not been read. The bench provokes this by placing a read exactly one cycle after a loopback write, on the edge where the indication switches. It expects `irq_o` still high and the new code visible. A second read must clear the interrupt, and the randomized command and read mix checks the same outcome against the bench's own model.

// File: rtl/l1_pwr_pkg.sv
package l1_pwr_pkg;
  localparam logic [3:0] CMD_L1_RST = 4'b0001;
  localparam logic [3:0] CMD_ZEROS  = 4'b0010;
  localparam logic [3:0] CMD_SZERO  = 4'b0011;
  localparam logic [3:0] CMD_ACT    = 4'b1000;
  localparam logic [3:0] CMD_LOOP   = 4'b1001;

  localparam logic [3:0] IND_DEACT  = 4'b1111;
  localparam logic [3:0] IND_ACTREQ = 4'b0100;
  localparam logic [3:0] IND_TEST   = 4'b1010;

  typedef struct packed {
    logic loop;
    logic zeros;
    logic act;
  } mode_t;
endpackage

// File: rtl/l1_pwr_sync.sv
module l1_pwr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/l1_pwr_cmd.sv
module l1_pwr_cmd
  import l1_pwr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [3:0] data_i,
  output mode_t      mode_o,
  output logic       l1_rst_o,
  output logic       szero_o
);
  mode_t mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= '0;
      l1_rst_o <= 1'b0;
      szero_o  <= 1'b0;
    end else begin
      l1_rst_o <= we_i && (data_i == CMD_L1_RST);
      szero_o  <= we_i && (data_i == CMD_SZERO);
      if (we_i) begin
        case (data_i)
          CMD_L1_RST: mode_q       <= '0;
          CMD_LOOP:   mode_q.loop  <= 1'b1;
          CMD_ZEROS:  mode_q.zeros <= 1'b1;
          CMD_ACT:    mode_q.act   <= 1'b1;
          default:    ;
        endcase
      end
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/l1_pwr_ind.sv
module l1_pwr_ind
  import l1_pwr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  mode_t      mode_i,
  input  logic       re_i,
  output logic [3:0] ind_o,
  output logic       irq_o
);
  logic [3:0] ind_q, ind_d;
  logic       irq_q;

  always_comb begin
    if (mode_i.loop || mode_i.zeros) ind_d = IND_TEST;
    else if (mode_i.act)             ind_d = IND_ACTREQ;
    else                             ind_d = IND_DEACT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ind_q <= IND_DEACT;
      irq_q <= 1'b0;
    end else begin
      ind_q <= ind_d;
      // a fresh change outranks a read in the same cycle
      if (ind_d != ind_q) irq_q <= 1'b1;
      else if (re_i)      irq_q <= 1'b0;
    end
  end

  assign ind_o = ind_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/l1_pwr_gate.sv
module l1_pwr_gate #(
  parameter int NUM_EN      = 3,
  parameter bit PD_ON_RESET = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  input  logic              cmd_we_i,
  input  logic              re_i,
  output logic [NUM_EN-1:0] en_o
);
  logic woke_q, read_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      woke_q <= !PD_ON_RESET;
      read_q <= 1'b0;
    end else begin
      if (line_i || cmd_we_i) woke_q <= 1'b1;
      if (re_i)               read_q <= 1'b1;
    end
  end

  generate
    for (genvar i = 0; i < NUM_EN; i++) begin : g_en
      assign en_o[i] = woke_q && read_q;
    end
  endgenerate
endmodule

// File: rtl/l1_pwr_ctrl.sv
module l1_pwr_ctrl
  import l1_pwr_pkg::*;
#(
  parameter int NUM_EN      = 3,
  parameter int SYNC_STAGES = 2,
  parameter bit PD_ON_RESET = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_active_i,
  input  logic              cmd_we_i,
  input  logic [3:0]        cmd_data_i,
  input  logic              ind_re_i,
  output logic [3:0]        ind_data_o,
  output logic              irq_o,
  output logic [NUM_EN-1:0] clk_en_o,
  output logic              loop_o,
  output logic              zeros_o,
  output logic              single_zero_o,
  output logic              l1_rst_o
);
  logic  line_s;
  mode_t mode;

  l1_pwr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_active_i),
    .q_o   (line_s)
  );

  l1_pwr_cmd u_cmd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cmd_we_i),
    .data_i  (cmd_data_i),
    .mode_o  (mode),
    .l1_rst_o(l1_rst_o),
    .szero_o (single_zero_o)
  );

  l1_pwr_ind u_ind (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mode_i(mode),
    .re_i  (ind_re_i),
    .ind_o (ind_data_o),
    .irq_o (irq_o)
  );

  l1_pwr_gate #(.NUM_EN(NUM_EN), .PD_ON_RESET(PD_ON_RESET)) u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .line_i  (line_s),
    .cmd_we_i(cmd_we_i),
    .re_i    (ind_re_i),
    .en_o    (clk_en_o)
  );

  assign loop_o  = mode.loop;
  assign zeros_o = mode.zeros;
endmodule

// File: rtl/l1_pwr_ctrl_chk.sv
module l1_pwr_ctrl_chk
  import l1_pwr_pkg::*;
#(
  parameter int NUM_EN = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_we_i,
  input logic [3:0]        cmd_data_i,
  input logic              ind_re_i,
  input logic [3:0]        ind_data_o,
  input logic              irq_o,
  input logic [NUM_EN-1:0] clk_en_o,
  input logic              loop_o,
  input logic              zeros_o,
  input logic              single_zero_o,
  input logic              l1_rst_o
);
  logic seen_read_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       seen_read_q <= 1'b0;
    else if (ind_re_i) seen_read_q <= 1'b1;
  end

  p_gated_until_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_read_q |-> (clk_en_o == '0));

  p_en_uniform_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_o == '0) || (clk_en_o == '1));

  p_en_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o[0] |=> clk_en_o[0]);

  p_loop_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loop_o && !(cmd_we_i && cmd_data_i == CMD_L1_RST)) |=> loop_o);

  p_zeros_held_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zeros_o && !(cmd_we_i && cmd_data_i == CMD_L1_RST)) |=> zeros_o);

  p_l1rst_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && cmd_data_i == CMD_L1_RST) |=> (!loop_o && !zeros_o && l1_rst_o));

  p_szero_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && cmd_data_i == CMD_SZERO) |=> single_zero_o);

  p_irq_on_change_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ind_data_o) |-> irq_o);

  p_ind_code_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ind_data_o == IND_DEACT) || (ind_data_o == IND_ACTREQ) || (ind_data_o == IND_TEST));
endmodule

bind l1_pwr_ctrl l1_pwr_ctrl_chk #(.NUM_EN(NUM_EN)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_we_i     (cmd_we_i),
  .cmd_data_i   (cmd_data_i),
  .ind_re_i     (ind_re_i),
  .ind_data_o   (ind_data_o),
  .irq_o        (irq_o),
  .clk_en_o     (clk_en_o),
  .loop_o       (loop_o),
  .zeros_o      (zeros_o),
  .single_zero_o(single_zero_o),
  .l1_rst_o     (l1_rst_o)
);

// File: tb/l1_pwr_ctrl_bench.sv
module l1_pwr_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_EN     = 3;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              line_active_i = 1'b0;
  logic              cmd_we_i = 1'b0;
  logic [3:0]        cmd_data_i = 4'h0;
  logic              ind_re_i = 1'b0;
  logic [3:0]        ind_data_o;
  logic              irq_o;
  logic [NUM_EN-1:0] clk_en_o;
  logic              loop_o, zeros_o, single_zero_o, l1_rst_o;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  l1_pwr_ctrl #(.NUM_EN(NUM_EN)) u_l1_pwr_ctrl (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_ind(input logic lp, input logic zr, input logic ac);
    if (lp || zr) return 4'b1010;
    if (ac)       return 4'b0100;
    return 4'b1111;
  endfunction

  task automatic wr(input logic [3:0] c);
    cmd_we_i = 1'b1; cmd_data_i = c;
    @(negedge clk_i);
    cmd_we_i = 1'b0;
  endtask

  task automatic rd();
    ind_re_i = 1'b1;
    @(negedge clk_i);
    ind_re_i = 1'b0;
  endtask

  task automatic do_reset(input logic line_in_reset);
    @(negedge clk_i);
    rst_ni = 1'b0;
    line_active_i = line_in_reset;
    repeat (3) @(negedge clk_i);
    line_active_i = 1'b0;
    #1;
    chk("R1 en in reset", 32'(clk_en_o), 0);
    rst_ni = 1'b1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : main
    logic m_loop, m_zeros, m_act;
    void'($urandom(32'd1234));

    // phase A: woken but unread keeps clocks gated
    do_reset(1'b0);
    @(negedge clk_i);
    chk("R1 clk_en", 32'(clk_en_o), 0);
    chk("R1 ind", 32'(ind_data_o), 32'hF);
    chk("R1 irq/modes", {irq_o, loop_o, zeros_o, single_zero_o, l1_rst_o}, 0);
    line_active_i = 1'b1;
    repeat (5) @(negedge clk_i);
    chk("R4 woken unread", 32'(clk_en_o), 0);
    rd();
    chk("R2 line wake after read", 32'(clk_en_o), 32'h7);
    line_active_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R5 stays enabled", 32'(clk_en_o), 32'h7);

    // phase B: line activity only during reset is ignored
    do_reset(1'b1);
    @(negedge clk_i);
    rd();
    repeat (6) @(negedge clk_i);
    chk("R13 no wake from reset-time line", 32'(clk_en_o), 0);
    chk("R4 read alone", 32'(clk_en_o), 0);
    wr(4'b0111);
    chk("R3 command wake", 32'(clk_en_o), 32'h7);
    @(negedge clk_i);
    chk("R12 unlisted modes", {loop_o, zeros_o}, 0);
    chk("R12 unlisted ind", 32'(ind_data_o), 32'hF);

    // directed mode sequence
    wr(4'b1001);
    chk("R6 loop set", 32'(loop_o), 1);
    @(negedge clk_i);
    chk("R10 test ind", 32'(ind_data_o), 32'hA);
    chk("R11 irq set", 32'(irq_o), 1);
    rd();
    chk("R11 irq cleared", 32'(irq_o), 0);
    wr(4'b1000);
    @(negedge clk_i);
    chk("R10 test overrides act", 32'(ind_data_o), 32'hA);
    wr(4'b0011);
    chk("R8 single zero pulse", 32'(single_zero_o), 1);
    chk("R8 loop kept", 32'(loop_o), 1);
    @(negedge clk_i);
    chk("R8 pulse ends", 32'(single_zero_o), 0);
    wr(4'b0010);
    chk("R6 zeros set", 32'(zeros_o), 1);
    wr(4'b0001);
    chk("R7 modes cleared", {loop_o, zeros_o}, 0);
    chk("R7 l1 reset pulse", 32'(l1_rst_o), 1);
    @(negedge clk_i);
    chk("R7 pulse ends", 32'(l1_rst_o), 0);
    chk("R7 act cleared ind", 32'(ind_data_o), 32'hF);
    wr(4'b1000);
    @(negedge clk_i);
    chk("R9 act ind", 32'(ind_data_o), 32'h4);
    rd();

    // collision: read strobe on the edge the indication changes
    wr(4'b1001);
    ind_re_i = 1'b1;
    @(negedge clk_i);
    ind_re_i = 1'b0;
    chk("R11 change wins over read", 32'(irq_o), 1);
    chk("R10 collision ind", 32'(ind_data_o), 32'hA);
    rd();
    chk("R11 clear after read", 32'(irq_o), 0);
    wr(4'b0001);
    @(negedge clk_i);
    rd();

    // random command mix against model
    m_loop = 0; m_zeros = 0; m_act = 0;
    for (int i = 0; i < 60; i++) begin
      logic [3:0] c;
      logic [3:0] prev;
      logic       do_rd;
      logic       exp_irq;
      case ($urandom % 6)
        0: c = 4'b0001;
        1: c = 4'b1001;
        2: c = 4'b0010;
        3: c = 4'b0011;
        4: c = 4'b1000;
        default: c = 4'b0110;
      endcase
      prev = exp_ind(m_loop, m_zeros, m_act);
      case (c)
        4'b0001: begin m_loop = 0; m_zeros = 0; m_act = 0; end
        4'b1001: m_loop = 1;
        4'b0010: m_zeros = 1;
        4'b1000: m_act = 1;
        default: ;
      endcase
      wr(c);
      chk("R6 random loop", 32'(loop_o), 32'(m_loop));
      chk("R6 random zeros", 32'(zeros_o), 32'(m_zeros));
      chk("R8 random pulse", 32'(single_zero_o), 32'(c == 4'b0011));
      chk("R7 random pulse", 32'(l1_rst_o), 32'(c == 4'b0001));
      do_rd = 1'($urandom % 2);
      ind_re_i = do_rd;
      @(negedge clk_i);
      ind_re_i = 1'b0;
      chk("R10 random ind", 32'(ind_data_o), 32'(exp_ind(m_loop, m_zeros, m_act)));
      exp_irq = (prev != exp_ind(m_loop, m_zeros, m_act)) ? 1'b1 : (do_rd ? 1'b0 : irq_o);
      if (prev != exp_ind(m_loop, m_zeros, m_act))
        chk("R11 random irq", 32'(irq_o), 32'(exp_irq));
      rd();
      chk("R11 random clear", 32'(irq_o), 0);
      chk("R5 random enabled", 32'(clk_en_o), 32'h7);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule